// File: doc/BRIEF.md
# Trap Entry State Unit

This block computes and registers the architectural state a processor takes on when it enters a trap. A trap request arrives with a 9-bit trap type and a delivery mode (privileged or hyperprivileged), together with the current values of the program counters and the control registers. On the clock edge that samples the request, the unit registers new values for the trap level, the global register level, the current window pointer and the two processor state words.

In the same edge it stores a snapshot of the interrupted context into a small per-level save file, one entry per trap level, selected by the new trap level. A read port lets the surrounding pipeline inspect any entry. Handler vectoring, arbitration between competing traps and the return path live elsewhere.

A trap that arrives when the trap level is already at its ceiling does not disturb any state. Instead it raises a sticky error indication.

Top module: `trap_entry_unit`

## Requirements
- R1: On an accepted trap, tl_o becomes tl_i+1 and the save-file entry for level tl_i+1 is written. Read level 0 or any level above MAX_TL returns all zeros.
- R2: The saved state word holds the fields shown below. Every other bit is zero.
  - cwp_i, zero-extended, in bits 4:0.
  - pstate_i in bits 20:8.
  - asi_i in bits 31:24.
  - ccr_i in bits 39:32.
  - gl_i in bits 42:40.
- R3: The saved entry also holds pc_i as the saved PC, npc_i as the saved next PC, hpstate_i as the saved hyper state and trap_type_i as the saved type.
- R4: gl_o becomes min(gl_i+1, cap). The cap is MAXGL_PRIV when hyp_mode_i=0 and MAXGL_HYP when hyp_mode_i=1.
- R5: In both modes, pstate_o has these changes from pstate_i. Every other bit keeps its value.
  - Bit 4 (float enable) is set.
  - Bit 3 (address mask) is cleared.
  - Bit 1 (interrupt enable) is cleared.
  - Bit 8 (trap endian) is kept.
- R6: With hyp_mode_i=0, pstate_o bit 2 (privileged) is set and bit 9 (current endian) is copied from pstate_i bit 8. With hyp_mode_i=1, both bits are cleared.
- R7: With hyp_mode_i=1, hpstate_o has these changes from hpstate_i. Every other bit is kept.
  - Bit 5 (recovery state) is cleared.
  - Bit 2 (hyper privileged) is set.
  - Bit 10 (breakpoint enable) is cleared.
  - Bit 0 is kept.
  With hyp_mode_i=0, hpstate_o equals hpstate_i.
- R8: The window pointer moves according to the trap type.
  - Type 0x024: cwp_o is cwp_i+1.
  - Types 0x080 to 0x0BF: cwp_o is cwp_i+cansave_i+2.
  - Types 0x0C0 to 0x0FF: cwp_o is cwp_i-1.
  - Any other type: cwp_o equals cwp_i.
- R9: The adjusted window pointer wraps modulo NWIN in both directions.
- R10: A trap with tl_i >= MAX_TL changes no output register and no save entry. It sets err_o, which stays high until reset.
- R11: done_o is high for exactly the one cycle after each edge that samples trap_req_i high. Without a trap, every output register holds its value.
- R12: After reset, the following are zero: tl_o, gl_o, cwp_o, pstate_o, hpstate_o, done_o, err_o and all save entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | Trap taken this cycle |
| trap_type_i | input | 9 | Trap type code |
| hyp_mode_i | input | 1 | 1 = hyperprivileged delivery, 0 = privileged |
| pc_i | input | 64 | Current PC |
| npc_i | input | 64 | Current next PC |
| tl_i | input | TL_W | Current trap level |
| gl_i | input | 3 | Current global level |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current address space identifier |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Saveable window count |
| pstate_i | input | 13 | Current processor state |
| hpstate_i | input | 11 | Current hyper state |
| tl_o | output | TL_W | New trap level |
| gl_o | output | 3 | New global level |
| cwp_o | output | CWP_W | New window pointer |
| pstate_o | output | 13 | New processor state |
| hpstate_o | output | 11 | New hyper state |
| done_o | output | 1 | Trap processed pulse |
| err_o | output | 1 | Sticky trap-level overflow |
| rd_lvl_i | input | TL_W | Save-file read level |
| rd_tstate_o | output | 64 | Saved state word |
| rd_tpc_o | output | 64 | Saved PC |
| rd_tnpc_o | output | 64 | Saved next PC |
| rd_htstate_o | output | 11 | Saved hyper state |
| rd_tt_o | output | 9 | Saved trap type |

## Verification
The hardest case to reach is a trap at the trap-level ceiling. That trap must leave every register and every save entry untouched while err_o sets. Because the current trap level is an input, the stimulus drives tl_i straight to MAX_TL and above, so no chain of nested traps is needed. It then sweeps the read level over all entries to confirm none moved. Window-pointer wrap needs cwp_i at 0 with a decrementing type, and at NWIN-1 with an incrementing or spill type with a large cansave. These cases are driven directly. A long random phase then mixes both modes and all type ranges.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int PC_W   = 64;
  localparam int TT_W   = 9;
  localparam int GL_W   = 3;
  localparam int PS_W   = 13;
  localparam int HPS_W  = 11;
  localparam int TS_W   = 64;

  // processor state bit positions
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;

  // hyper state bit positions
  localparam int HP_HPRIV = 2;
  localparam int HP_RED   = 5;
  localparam int HP_IBE   = 10;

  // saved-state word field positions (decoded by the return path)
  localparam int TS_CWP_LO = 0;
  localparam int TS_PS_LO  = 8;
  localparam int TS_ASI_LO = 24;
  localparam int TS_CCR_LO = 32;
  localparam int TS_GL_LO  = 40;

  typedef struct packed {
    logic [TS_W-1:0]  tstate;
    logic [PC_W-1:0]  tpc;
    logic [PC_W-1:0]  tnpc;
    logic [HPS_W-1:0] htstate;
    logic [TT_W-1:0]  tt;
  } save_ent_t;

endpackage

// File: rtl/trap_cwp_rot.sv
module trap_cwp_rot
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWP_W = $clog2(NWIN)
) (
  input  logic [TT_W-1:0]  tt_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             moved_o
);

  function automatic logic [1:0] range_code(input logic [TT_W-1:0] tt);
    if (tt == 9'h024)                      return 2'd1;
    else if (tt >= 9'h080 && tt <= 9'h0BF) return 2'd2;
    else if (tt >= 9'h0C0 && tt <= 9'h0FF) return 2'd3;
    else                                   return 2'd0;
  endfunction

  function automatic logic [CWP_W-1:0] rotate(input logic [1:0] code,
                                              input logic [CWP_W-1:0] cwp,
                                              input logic [CWP_W-1:0] cs);
    logic [31:0] base;
    logic [31:0] sum;
    base = 32'(cwp);
    case (code)
      2'd1:    sum = base + 32'd1;
      2'd2:    sum = base + 32'(cs) + 32'd2;
      2'd3:    sum = base + 32'(NWIN) - 32'd1;
      default: sum = base;
    endcase
    if (code == 2'd0) return cwp;
    return CWP_W'(sum % 32'(NWIN));
  endfunction

  logic [1:0] code;

  always_comb begin
    code    = range_code(tt_i);
    moved_o = (code != 2'd0);
    cwp_o   = rotate(code, cwp_i, cansave_i);
  end

endmodule

// File: rtl/trap_state_calc.sv
module trap_state_calc
  import trap_pkg::*;
#(
  parameter int CWP_W      = 3,
  parameter int MAXGL_PRIV = 2,
  parameter int MAXGL_HYP  = 3
) (
  input  logic             hyp_i,
  input  logic [GL_W-1:0]  gl_i,
  input  logic [7:0]       ccr_i,
  input  logic [7:0]       asi_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [PS_W-1:0]  pstate_i,
  input  logic [HPS_W-1:0] hpstate_i,
  output logic [GL_W-1:0]  gl_o,
  output logic [PS_W-1:0]  pstate_o,
  output logic [HPS_W-1:0] hpstate_o,
  output logic [TS_W-1:0]  tstate_o
);

  function automatic logic [GL_W-1:0] gl_step(input logic [GL_W-1:0] gl,
                                              input logic hyp);
    logic [GL_W:0] inc;
    logic [GL_W:0] cap;
    inc = {1'b0, gl} + 1'b1;
    cap = hyp ? (GL_W+1)'(MAXGL_HYP) : (GL_W+1)'(MAXGL_PRIV);
    return (inc > cap) ? cap[GL_W-1:0] : inc[GL_W-1:0];
  endfunction

  function automatic logic [PS_W-1:0] ps_step(input logic [PS_W-1:0] ps,
                                              input logic hyp);
    logic [PS_W-1:0] r;
    r          = ps;
    r[PS_PEF]  = 1'b1;
    r[PS_AM]   = 1'b0;
    r[PS_IE]   = 1'b0;
    r[PS_PRIV] = ~hyp;
    r[PS_CLE]  = hyp ? 1'b0 : ps[PS_TLE];
    return r;
  endfunction

  function automatic logic [HPS_W-1:0] hp_step(input logic [HPS_W-1:0] hp,
                                               input logic hyp);
    logic [HPS_W-1:0] r;
    r = hp;
    if (hyp) begin
      r[HP_RED]   = 1'b0;
      r[HP_HPRIV] = 1'b1;
      r[HP_IBE]   = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [TS_W-1:0] ts_pack(input logic [GL_W-1:0] gl,
                                              input logic [7:0] ccr,
                                              input logic [7:0] asi,
                                              input logic [PS_W-1:0] ps,
                                              input logic [CWP_W-1:0] cwp);
    logic [TS_W-1:0] w;
    w = '0;
    w[TS_GL_LO  +: GL_W]  = gl;
    w[TS_CCR_LO +: 8]     = ccr;
    w[TS_ASI_LO +: 8]     = asi;
    w[TS_PS_LO  +: PS_W]  = ps;
    w[TS_CWP_LO +: CWP_W] = cwp;
    return w;
  endfunction

  always_comb begin
    gl_o      = gl_step(gl_i, hyp_i);
    pstate_o  = ps_step(pstate_i, hyp_i);
    hpstate_o = hp_step(hpstate_i, hyp_i);
    tstate_o  = ts_pack(gl_i, ccr_i, asi_i, pstate_i, cwp_i);
  end

endmodule

// File: rtl/trap_save_file.sv
module trap_save_file
  import trap_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  save_ent_t        wdata_i,
  input  logic [LVL_W-1:0] rd_lvl_i,
  output save_ent_t        rdata_o
);

  save_ent_t        ent_q [DEPTH];
  logic [DEPTH-1:0] wr_hit;
  logic [DEPTH-1:0] rd_hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_dec
    assign wr_hit[e] = we_i && (wr_lvl_i == LVL_W'(e + 1));
    assign rd_hit[e] = (rd_lvl_i == LVL_W'(e + 1));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rst_n)         ent_q[e] <= '0;
      else if (wr_hit[e]) ent_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_hit[e]) rdata_o = ent_q[e];
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int NWIN       = 8,
  parameter int MAX_TL     = 6,
  parameter int MAXGL_PRIV = 2,
  parameter int MAXGL_HYP  = 3,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int CWP_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic             hyp_mode_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [GL_W-1:0]  gl_i,
  input  logic [7:0]       ccr_i,
  input  logic [7:0]       asi_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  input  logic [PS_W-1:0]  pstate_i,
  input  logic [HPS_W-1:0] hpstate_i,
  output logic [TL_W-1:0]  tl_o,
  output logic [GL_W-1:0]  gl_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [PS_W-1:0]  pstate_o,
  output logic [HPS_W-1:0] hpstate_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [TL_W-1:0]  rd_lvl_i,
  output logic [TS_W-1:0]  rd_tstate_o,
  output logic [PC_W-1:0]  rd_tpc_o,
  output logic [PC_W-1:0]  rd_tnpc_o,
  output logic [HPS_W-1:0] rd_htstate_o,
  output logic [TT_W-1:0]  rd_tt_o
);

  // named internal events
  logic             tl_full;
  logic             accept;
  logic [TL_W-1:0]  tl_next;
  logic [GL_W-1:0]  gl_next;
  logic [CWP_W-1:0] cwp_next;
  logic             cwp_moved;
  logic [PS_W-1:0]  ps_next;
  logic [HPS_W-1:0] hps_next;
  logic [TS_W-1:0]  ts_word;
  save_ent_t        save_wdata;
  save_ent_t        save_rdata;

  assign tl_full = (tl_i >= TL_W'(MAX_TL));
  assign accept  = trap_req_i && !tl_full;
  assign tl_next = tl_i + 1'b1;

  trap_cwp_rot #(.NWIN(NWIN)) u_rot (
    .tt_i      (trap_type_i),
    .cwp_i     (cwp_i),
    .cansave_i (cansave_i),
    .cwp_o     (cwp_next),
    .moved_o   (cwp_moved)
  );

  trap_state_calc #(
    .CWP_W      (CWP_W),
    .MAXGL_PRIV (MAXGL_PRIV),
    .MAXGL_HYP  (MAXGL_HYP)
  ) u_calc (
    .hyp_i     (hyp_mode_i),
    .gl_i      (gl_i),
    .ccr_i     (ccr_i),
    .asi_i     (asi_i),
    .cwp_i     (cwp_i),
    .pstate_i  (pstate_i),
    .hpstate_i (hpstate_i),
    .gl_o      (gl_next),
    .pstate_o  (ps_next),
    .hpstate_o (hps_next),
    .tstate_o  (ts_word)
  );

  always_comb begin
    save_wdata.tstate  = ts_word;
    save_wdata.tpc     = pc_i;
    save_wdata.tnpc    = npc_i;
    save_wdata.htstate = hpstate_i;
    save_wdata.tt      = trap_type_i;
  end

  trap_save_file #(.DEPTH(MAX_TL), .LVL_W(TL_W)) u_save (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (accept),
    .wr_lvl_i (tl_next),
    .wdata_i  (save_wdata),
    .rd_lvl_i (rd_lvl_i),
    .rdata_o  (save_rdata)
  );

  assign rd_tstate_o  = save_rdata.tstate;
  assign rd_tpc_o     = save_rdata.tpc;
  assign rd_tnpc_o    = save_rdata.tnpc;
  assign rd_htstate_o = save_rdata.htstate;
  assign rd_tt_o      = save_rdata.tt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_o      <= '0;
      gl_o      <= '0;
      cwp_o     <= '0;
      pstate_o  <= '0;
      hpstate_o <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= trap_req_i;
      if (trap_req_i && tl_full) err_o <= 1'b1;
      if (accept) begin
        tl_o      <= tl_next;
        gl_o      <= gl_next;
        cwp_o     <= cwp_next;
        pstate_o  <= ps_next;
        hpstate_o <= hps_next;
      end
    end
  end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int MAX_TL     = 6,
  parameter int MAXGL_PRIV = 2,
  parameter int MAXGL_HYP  = 3,
  parameter int TL_W       = 3,
  parameter int CWP_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_req_i,
  input logic             hyp_mode_i,
  input logic [TL_W-1:0]  tl_i,
  input logic [CWP_W-1:0] cwp_i,
  input logic [HPS_W-1:0] hpstate_i,
  input logic [TL_W-1:0]  tl_o,
  input logic [GL_W-1:0]  gl_o,
  input logic [CWP_W-1:0] cwp_o,
  input logic [PS_W-1:0]  pstate_o,
  input logic [HPS_W-1:0] hpstate_o,
  input logic             done_o,
  input logic             err_o,
  input logic             accept,
  input logic             tl_full,
  input logic             cwp_moved
);

  a_r1_tl_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tl_o == $past(tl_i) + 1'b1);

  a_r4_gl_priv_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hyp_mode_i) |=> gl_o <= GL_W'(MAXGL_PRIV));

  a_r4_gl_hyp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hyp_mode_i) |=> gl_o <= GL_W'(MAXGL_HYP));

  a_r5_pstate_common: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pstate_o[PS_PEF] && !pstate_o[PS_AM] && !pstate_o[PS_IE]));

  a_r6_priv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pstate_o[PS_PRIV] == !$past(hyp_mode_i));

  a_r7_hyp_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hyp_mode_i) |=>
      (!hpstate_o[HP_RED] && hpstate_o[HP_HPRIV] && !hpstate_o[HP_IBE]));

  a_r7_priv_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hyp_mode_i) |=> hpstate_o == $past(hpstate_i));

  a_r8_cwp_still: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cwp_moved) |=> cwp_o == $past(cwp_i));

  a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && tl_full) |=> (err_o && $stable(tl_o) && $stable(pstate_o)));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i |=> done_o);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req_i |=> (!done_o && $stable(tl_o) && $stable(gl_o) && $stable(cwp_o)));

  a_r1_tl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tl_o <= TL_W'(MAX_TL));

endmodule

bind trap_entry_unit trap_entry_chk #(
  .MAX_TL     (MAX_TL),
  .MAXGL_PRIV (MAXGL_PRIV),
  .MAXGL_HYP  (MAXGL_HYP),
  .TL_W       (TL_W),
  .CWP_W      (CWP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req_i (trap_req_i),
  .hyp_mode_i (hyp_mode_i),
  .tl_i       (tl_i),
  .cwp_i      (cwp_i),
  .hpstate_i  (hpstate_i),
  .tl_o       (tl_o),
  .gl_o       (gl_o),
  .cwp_o      (cwp_o),
  .pstate_o   (pstate_o),
  .hpstate_o  (hpstate_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .accept     (accept),
  .tl_full    (tl_full),
  .cwp_moved  (cwp_moved)
);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

  localparam int NWIN = 8;
  localparam int MAXT = 6;
  localparam int GPRV = 2;
  localparam int GHYP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [8:0]  ttype = '0;
  logic        hyp = 1'b0;
  logic [63:0] pc = '0, npc = '0;
  logic [2:0]  tl_in = '0, gl_in = '0, cwp_in = '0, cs_in = '0, rd_lvl = '0;
  logic [7:0]  ccr = '0, asi = '0;
  logic [12:0] ps_in = '0;
  logic [10:0] hps_in = '0;
  logic [2:0]  tl_o, gl_o, cwp_o;
  logic [12:0] ps_o;
  logic [10:0] hps_o;
  logic        done_o, err_o;
  logic [63:0] r_ts, r_pc, r_npc;
  logic [10:0] r_hts;
  logic [8:0]  r_tt;

  always #5 clk = ~clk;

  trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAXT), .MAXGL_PRIV(GPRV), .MAXGL_HYP(GHYP))
  u_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_type_i(ttype),
    .hyp_mode_i(hyp), .pc_i(pc), .npc_i(npc), .tl_i(tl_in), .gl_i(gl_in),
    .ccr_i(ccr), .asi_i(asi), .cwp_i(cwp_in), .cansave_i(cs_in),
    .pstate_i(ps_in), .hpstate_i(hps_in), .tl_o(tl_o), .gl_o(gl_o),
    .cwp_o(cwp_o), .pstate_o(ps_o), .hpstate_o(hps_o), .done_o(done_o),
    .err_o(err_o), .rd_lvl_i(rd_lvl), .rd_tstate_o(r_ts), .rd_tpc_o(r_pc),
    .rd_tnpc_o(r_npc), .rd_htstate_o(r_hts), .rd_tt_o(r_tt)
  );

  // behavioural reference model
  int unsigned m_tl, m_gl, m_cwp, m_ps, m_hps, m_done, m_err;
  logic [63:0] m_ts [8], m_pc [8], m_npc [8];
  int unsigned m_hts [8], m_tt [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tl = 0; m_gl = 0; m_cwp = 0; m_ps = 0; m_hps = 0; m_done = 0; m_err = 0;
      for (int i = 0; i < 8; i++) begin
        m_ts[i] = 0; m_pc[i] = 0; m_npc[i] = 0; m_hts[i] = 0; m_tt[i] = 0;
      end
    end else begin
      m_done = trap_req;
      if (trap_req && tl_in >= MAXT) m_err = 1;
      else if (trap_req) begin
        int unsigned lvl, cap, g, p, h;
        int c, t;
        lvl = tl_in + 1;
        m_ts[lvl] = (64'(gl_in) << 40) | (64'(ccr) << 32) | (64'(asi) << 24)
                  | (64'(ps_in) << 8) | 64'(cwp_in);
        m_pc[lvl] = pc; m_npc[lvl] = npc; m_hts[lvl] = hps_in; m_tt[lvl] = ttype;
        m_tl = lvl;
        cap = hyp ? GHYP : GPRV;
        g = gl_in + 1;
        m_gl = (g > cap) ? cap : g;
        p = ps_in;
        p = (p | 16) & ~32'd8 & ~32'd2;
        if (!hyp) p = (p | 4) & ~32'd512 | (((p >> 8) & 1) << 9);
        else      p = p & ~32'd4 & ~32'd512;
        m_ps = p;
        h = hps_in;
        if (hyp) h = ((h & ~32'd32) | 4) & ~32'd1024;
        m_hps = h;
        t = int'(ttype);
        c = int'(cwp_in);
        if (t == 36)                   c = c + 1;
        else if (t >= 128 && t < 192)  c = c + int'(cs_in) + 2;
        else if (t >= 192 && t < 256)  c = c - 1;
        m_cwp = ((c % NWIN) + NWIN) % NWIN;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int unsigned l;
    logic [63:0] ets, epc, enpc;
    int unsigned ehts, ett;
    l = rd_lvl;
    if (l >= 1 && l <= MAXT) begin
      ets = m_ts[l]; epc = m_pc[l]; enpc = m_npc[l]; ehts = m_hts[l]; ett = m_tt[l];
    end else begin
      ets = 0; epc = 0; enpc = 0; ehts = 0; ett = 0;
    end
    chk(tl_o == 3'(m_tl), "R1 tl", 64'(tl_o), 64'(m_tl));
    chk(gl_o == 3'(m_gl), "R4 gl", 64'(gl_o), 64'(m_gl));
    chk(ps_o == 13'(m_ps), "R5/R6 pstate", 64'(ps_o), 64'(m_ps));
    chk(hps_o == 11'(m_hps), "R7 hpstate", 64'(hps_o), 64'(m_hps));
    chk(cwp_o == 3'(m_cwp), "R8/R9 cwp", 64'(cwp_o), 64'(m_cwp));
    chk(done_o == m_done[0], "R11 done", 64'(done_o), 64'(m_done));
    chk(err_o == m_err[0], "R10 err", 64'(err_o), 64'(m_err));
    chk(r_ts == ets, "R2 tstate", r_ts, ets);
    chk(r_pc == epc && r_npc == enpc, "R3 tpc/tnpc", r_pc ^ r_npc, epc ^ enpc);
    chk(r_hts == 11'(ehts) && r_tt == 9'(ett), "R3 htstate/tt",
        {r_hts, r_tt}, 64'({11'(ehts), 9'(ett)}));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic fill_ctx();
    pc = {$urandom, $urandom}; npc = {$urandom, $urandom};
    ccr = 8'($urandom); asi = 8'($urandom);
    ps_in = 13'($urandom); hps_in = 11'($urandom);
    gl_in = 3'($urandom); cansave_set();
  endtask

  task automatic cansave_set();
    cs_in = 3'($urandom);
  endtask

  task automatic one_trap(input logic [8:0] t, input logic h, input logic [2:0] tl,
                          input logic [2:0] cw);
    fill_ctx();
    ttype = t; hyp = h; tl_in = tl; cwp_in = cw;
    rd_lvl = tl + 3'd1;
    trap_req = 1'b1;
    step();
    trap_req = 1'b0;
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state, every level read back
    for (int l = 0; l < 8; l++) begin
      rd_lvl = 3'(l);
      step();
      chk(tl_o == 0 && gl_o == 0 && cwp_o == 0 && ps_o == 0 && !err_o,
          "R12 reset", 64'({tl_o, gl_o, cwp_o}), 64'd0);
    end
    // R8 window moves per type range; R9 wrap at both ends
    one_trap(9'h024, 1'b0, 3'd0, 3'd7);
    chk(cwp_o == 3'd0, "R9 wrap up", 64'(cwp_o), 64'd0);
    one_trap(9'h0C5, 1'b0, 3'd1, 3'd0);
    chk(cwp_o == 3'd7, "R9 wrap down", 64'(cwp_o), 64'd7);
    cs_in = 3'd7;
    ttype = 9'h0BF; hyp = 1'b0; tl_in = 3'd2; cwp_in = 3'd6; trap_req = 1'b1;
    step(); trap_req = 1'b0;
    chk(cwp_o == 3'd7, "R8 spill range", 64'(cwp_o), 64'd7);
    one_trap(9'h0FF, 1'b1, 3'd3, 3'd4);
    one_trap(9'h100, 1'b1, 3'd4, 3'd5);
    chk(cwp_o == 3'd5, "R8 outside ranges", 64'(cwp_o), 64'd5);
    one_trap(9'h07F, 1'b0, 3'd5, 3'd2);
    // R4 caps in each mode
    gl_in = 3'd7; hyp = 1'b0; tl_in = 3'd0; ttype = 9'h010; trap_req = 1'b1;
    step(); trap_req = 1'b0;
    chk(gl_o == 3'(GPRV), "R4 priv cap", 64'(gl_o), 64'(GPRV));
    gl_in = 3'd2; hyp = 1'b1; trap_req = 1'b1;
    step(); trap_req = 1'b0;
    chk(gl_o == 3'(GHYP), "R4 hyp cap", 64'(gl_o), 64'(GHYP));
    // R6 endian copy in privileged mode
    ps_in = 13'h100; hyp = 1'b0; trap_req = 1'b1;
    step(); trap_req = 1'b0;
    chk(ps_o == 13'h314, "R6 cle from tle", 64'(ps_o), 64'h314);
    // R10 ceiling: nothing moves, all levels unchanged
    one_trap(9'h024, 1'b1, 3'(MAXT), 3'd3);
    chk(err_o == 1'b1, "R10 err set", 64'(err_o), 64'd1);
    one_trap(9'h080, 1'b0, 3'd7, 3'd1);
    for (int l = 0; l < 8; l++) begin
      rd_lvl = 3'(l);
      step();
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      fill_ctx();
      ttype = 9'($urandom);
      if (n % 3 == 0) ttype = 9'h080 + 9'($urandom_range(0, 127));
      hyp = 1'($urandom);
      tl_in = 3'($urandom);
      cwp_in = 3'($urandom);
      rd_lvl = 3'($urandom);
      trap_req = 1'($urandom);
      step();
    end
    trap_req = 1'b0;
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule